// File: doc/BRIEF.md
# Serial Result Readout Port

This block is the output side of a successive-approximation converter. It keeps the most recent conversion word and sends it on a single serial data line. The line is driven only while the active-low chip select is asserted, so several converters can share it. A host can collect the data in one of two ways. It can hold chip select low through a conversion and take each bit as the conversion logic decides it, at the conversion-clock rate. It can also wait until the conversion is finished and clock the stored word out later on a serial clock that is unrelated to the conversion clock.

The stored word is loaded only when the conversion logic reports a finished conversion. If a conversion finishes while the host still holds chip select low, the new word waits in a holding register. It is moved into the stored word once the synchronized chip select shows the port deselected. Because of this, a word never changes part way through a read. Every new chip-select assertion starts again at the most significant bit, so reading twice gives the same word twice.

Top module: `adc_serial_readout`

## Requirements
- R1: `dout_oe` is 1 exactly while `cs_n` is 0. While `cs_n` is 1, `dout` is held at 0.
- R2: When `cs_n` falls while `conv_active` is 0, `dout` shows bit 15 (the MSB) of the stored word before any `sclk` edge.
- R3: Each falling `sclk` edge with `cs_n` low advances the output by one bit toward the LSB. After the 15th falling edge, `dout` shows bit 0.
- R4: From the 16th falling `sclk` edge of a selection until `cs_n` rises, `dout` is 0.
- R5: While `conv_active` is 1 and `cs_n` is 0, `dout` equals `live_bit`. This is the in-conversion bit stream.
- R6: A `conv_done` pulse, sampled on a rising `clk` edge while the synchronized chip select reads deselected, loads `result` into the stored word at that edge. The stored word does not change in any cycle without a finished conversion or a pending word.
- R7: A `conv_done` pulse seen while the synchronized chip select reads selected leaves the stored word unchanged. The new word is held pending and is loaded by the third rising `clk` edge after `cs_n` rises.
- R8: Each falling edge of `cs_n` restarts the read at the MSB, so back-to-back reads return the same word.
- R9: A synchronous active-low `rst_n` clears the stored word to zero and drops any pending word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset, clk domain |
| conv_active | input | 1 | High while a conversion is in progress, clk domain |
| live_bit | input | 1 | Bit currently decided by the conversion logic |
| conv_done | input | 1 | One-cycle pulse when a conversion completes |
| result | input | 16 | Completed conversion word, valid with conv_done |
| cs_n | input | 1 | Active-low chip select, asynchronous |
| sclk | input | 1 | Serial readout clock, asynchronous to clk, idles low |
| dout | output | 1 | Serial data, MSB first |
| dout_oe | output | 1 | Output enable for the three-state data pad |

## Verification
The bench runs three kinds of read and checks each one bit by bit: reads at the serial clock, overruns past the LSB, and reads taken during a conversion. A design that loads the MSB only on the first serial edge would fail the check made right after chip select falls. An off-by-one in the bit counter would misplace the LSB or repeat a bit before the zero fill. The bench also ends conversions while chip select is still low, to test deferred loading. If the stored word is overwritten in the middle of a read, the rest of that read comes out corrupted. If the pending word is dropped, the next read returns the old word. Repeated reads and random stored-versus-live selection test that the counter restarts on every chip-select fall.

// File: rtl/adc_rd_pkg.sv
// Package: shared widths and types for the serial readout port.
package adc_rd_pkg;
    // Default conversion word width.
    localparam int unsigned RD_DATA_W = 16;
    // Default number of flops in the chip-select synchronizer.
    localparam int unsigned RD_SYNC_STAGES = 2;

    // Which path feeds the data line.
    typedef enum logic {
        SRC_STORED = 1'b0,
        SRC_LIVE   = 1'b1
    } rd_src_e;
endpackage

// File: rtl/rd_result_store.sv
// Module: rd_result_store
// Holds the last completed conversion word in the clk domain.
// It synchronizes cs_n into clk and defers any word that finishes while
// the port is selected, so the stored word never changes during a read.
// Assumes: conv_done is a single-cycle pulse synchronous to clk.
module rd_result_store #(
    parameter int unsigned DATA_W      = adc_rd_pkg::RD_DATA_W,
    parameter int unsigned SYNC_STAGES = adc_rd_pkg::RD_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] hold_q,
    output logic              pend_q,
    output logic              cs_sync_n
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic [DATA_W-1:0]      pend_word_q;

    // Synchronizer chain carrying chip select into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sync_q[i] <= sync_q[i-1];
            end
            sync_q[0] <= cs_n;
        end
    end

    assign cs_sync_n = sync_q[SYNC_STAGES-1];

    // Load or defer a finished word, and drain the pending word once deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            pend_word_q <= '0;
            pend_q      <= 1'b0;
        end else if (conv_done) begin
            if (cs_sync_n) begin
                hold_q <= result;
                pend_q <= 1'b0;
            end else begin
                pend_word_q <= result;
                pend_q      <= 1'b1;
            end
        end else if (pend_q && cs_sync_n) begin
            hold_q <= pend_word_q;
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rd_bit_sequencer.sv
// Module: rd_bit_sequencer
// Serial-clock-domain bit selector. A counter, cleared asynchronously while
// chip select is high, counts falling sclk edges. It picks MSB first from
// the stored word and gives zeros once the LSB has gone out.
// Assumes: the stored word is stable while cs_n is low (the store ensures it).
module rd_bit_sequencer #(
    parameter int unsigned DATA_W = adc_rd_pkg::RD_DATA_W
) (
    input  logic              sclk,
    input  logic              cs_n,
    input  logic [DATA_W-1:0] word,
    output logic              stored_bit
);
    localparam int unsigned CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(DATA_W);

    logic [CNT_W-1:0] cnt_q;

    // Count falling sclk edges within a selection; saturate past the LSB.
    always_ff @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_END) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Choose the bit that matches the count, or zero after the LSB.
    always_comb begin
        stored_bit = 1'b0;
        if (cnt_q < CNT_END) begin
            stored_bit = word[DATA_W - 1 - int'(cnt_q)];
        end
    end
endmodule

// File: rtl/rd_line_driver.sv
// Module: rd_line_driver
// Selects between the live conversion bit and the stored-word bit, and
// makes the three-state enable. The line is forced low when not enabled.
// Assumes: conv_active and live_bit come from the conversion logic in clk domain.
module rd_line_driver (
    input  logic cs_n,
    input  logic conv_active,
    input  logic live_bit,
    input  logic stored_bit,
    output logic dout,
    output logic dout_oe
);
    import adc_rd_pkg::*;

    rd_src_e src;

    // Choose the data source from the conversion state.
    always_comb begin
        src = conv_active ? SRC_LIVE : SRC_STORED;
    end

    // Drive the line only while selected.
    always_comb begin
        dout_oe = ~cs_n;
        if (cs_n) begin
            dout = 1'b0;
        end else if (src == SRC_LIVE) begin
            dout = live_bit;
        end else begin
            dout = stored_bit;
        end
    end
endmodule

// File: rtl/adc_serial_readout.sv
// Module: adc_serial_readout
// Top of the chip-selected serial readout port. It ties together the
// clk-domain result store, the sclk-domain bit sequencer and the line driver.
// Assumes: sclk idles low and is asynchronous to clk; rst_n is synchronous to clk.
module adc_serial_readout #(
    parameter int unsigned DATA_W      = adc_rd_pkg::RD_DATA_W,
    parameter int unsigned SYNC_STAGES = adc_rd_pkg::RD_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_active,
    input  logic              live_bit,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] result,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              dout,
    output logic              dout_oe
);
    logic [DATA_W-1:0] hold_q;
    logic              pend_q;
    logic              cs_sync_n;
    logic              stored_bit;

    rd_result_store #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .conv_done (conv_done),
        .result    (result),
        .hold_q    (hold_q),
        .pend_q    (pend_q),
        .cs_sync_n (cs_sync_n)
    );

    rd_bit_sequencer #(
        .DATA_W (DATA_W)
    ) u_seq (
        .sclk       (sclk),
        .cs_n       (cs_n),
        .word       (hold_q),
        .stored_bit (stored_bit)
    );

    rd_line_driver u_drv (
        .cs_n        (cs_n),
        .conv_active (conv_active),
        .live_bit    (live_bit),
        .stored_bit  (stored_bit),
        .dout        (dout),
        .dout_oe     (dout_oe)
    );
endmodule

// File: rtl/adc_serial_readout_chk.sv
// Module: adc_serial_readout_chk
// Property checker for the readout port, attached by bind.
module adc_serial_readout_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_active,
    input logic              live_bit,
    input logic              conv_done,
    input logic [DATA_W-1:0] result,
    input logic              cs_n,
    input logic              dout,
    input logic              dout_oe,
    input logic [DATA_W-1:0] hold_q,
    input logic              pend_q,
    input logic              cs_sync_n
);
    AST_LINE_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!dout_oe && !dout)); // R1
    AST_LIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && conv_active) |-> (dout == live_bit)); // R5
    AST_LOAD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && cs_sync_n) |=> (hold_q == $past(result))); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_done && !pend_q) |=> $stable(hold_q)); // R6
    AST_DEFER_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !cs_sync_n) |=> ($stable(hold_q) && pend_q)); // R7
    AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && cs_sync_n && !conv_done) |=> !pend_q); // R7
endmodule

bind adc_serial_readout adc_serial_readout_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_active (conv_active),
    .live_bit    (live_bit),
    .conv_done   (conv_done),
    .result      (result),
    .cs_n        (cs_n),
    .dout        (dout),
    .dout_oe     (dout_oe),
    .hold_q      (hold_q),
    .pend_q      (pend_q),
    .cs_sync_n   (cs_sync_n)
);

// File: tb/test_adc_serial_readout.sv
`timescale 1ns/1ps
module test_adc_serial_readout;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_active = 1'b0;
    logic         live_bit = 1'b0;
    logic         conv_done = 1'b0;
    logic [W-1:0] result = '0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         dout;
    logic         dout_oe;

    int           n_checks = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;
    logic [W-1:0] exp_word = '0;

    adc_serial_readout i_adc_serial_readout (
        .clk(clk), .rst_n(rst_n), .conv_active(conv_active), .live_bit(live_bit),
        .conv_done(conv_done), .result(result), .cs_n(cs_n), .sclk(sclk),
        .dout(dout), .dout_oe(dout_oe)
    );

    always #4 clk = ~clk;

    // Expected stored-path bit after n falling serial edges.
    function automatic logic exp_bit(input logic [W-1:0] w, input int n);
        return (n < W) ? w[W-1-n] : 1'b0;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Full stored-path read with a given number of extra pulses past the LSB.
    task automatic do_read(input int extra);
        cs_n = 1'b0;
        #6;
        check(dout_oe, 1'b1, "R1 enable while selected");
        check(dout, exp_bit(exp_word, 0), "R2 MSB before sclk / R8 restart");
        for (int n = 1; n <= W - 1 + extra; n++) begin
            sclk = 1'b1; #21;
            sclk = 1'b0; #6;
            if (n < W) check(dout, exp_bit(exp_word, n), "R3 shifted bit");
            else       check(dout, 1'b0, "R4 zero fill");
            #15;
        end
        cs_n = 1'b1;
        #3;
        check(dout_oe, 1'b0, "R1 disable after deselect");
        check(dout, 1'b0, "R1 line low when deselected");
        repeat (5) @(posedge clk);
    endtask

    // Conversion with random live bits; optionally watched with cs_n low.
    task automatic do_conv(input logic [W-1:0] w, input bit watch);
        @(negedge clk);
        if (watch) cs_n = 1'b0;
        conv_active = 1'b1;
        for (int i = 0; i < W; i++) begin
            live_bit = 1'($urandom);
            #2;
            if (watch) check(dout, live_bit, "R5 live bit");
            else begin
                check(dout_oe, 1'b0, "R1 deselected during conversion");
                check(dout, 1'b0, "R1 line low during conversion");
            end
            @(negedge clk);
        end
        conv_active = 1'b0;
        conv_done = 1'b1;
        result = w;
        @(negedge clk);
        conv_done = 1'b0;
        if (watch) begin
            // R7: stored path still shows the old word while selected.
            #1;
            check(dout, exp_bit(exp_word, 0), "R7 old MSB kept while selected");
            repeat (3) @(negedge clk);
            check(dout, exp_bit(exp_word, 0), "R7 old MSB still kept");
            cs_n = 1'b1;
        end
        repeat (5) @(posedge clk);
        exp_word = w;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(dout_oe, 1'b0, "R1 reset state enable");
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R9: stored word is zero after reset.
        exp_word = '0;
        do_read(2);
        // Directed: alternating pattern, MSB-only and LSB-only words.
        do_conv(16'hA5C3, 1'b0); do_read(1);
        do_read(0);
        do_conv(16'h8000, 1'b0); do_read(3);
        do_conv(16'h0001, 1'b1); do_read(2);
        // R8: repeated read gives the same word.
        do_read(0);
        // R7: deferred word during a stored-path read.
        cs_n = 1'b0; #20;
        @(negedge clk); conv_done = 1'b1; result = 16'h7FFE;
        @(negedge clk); conv_done = 1'b0;
        repeat (3) @(negedge clk);
        check(dout, exp_bit(exp_word, 0), "R7 deferred while reading");
        cs_n = 1'b1;
        repeat (5) @(posedge clk);
        exp_word = 16'h7FFE;
        do_read(1);
        // Random mix.
        for (int k = 0; k < 24; k++) begin
            do_conv(W'($urandom), 1'($urandom));
            do_read(int'($urandom_range(0, 4)));
            if ($urandom_range(0, 2) == 0) do_read(0);
        end
        // R9: reset clears the word.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        exp_word = '0;
        repeat (3) @(posedge clk);
        do_read(0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule